// File: doc/BRIEF.md
# Dual-Reload Programmable Timer Channel

This block is one timer/counter channel of a multi-channel timer array. It runs from the 50 MHz system clock. It holds a count register of `WIDTH` bits, a running flag and an output toggle flip-flop. A mode word, supplied as a plain input by the surrounding register logic, sets how the channel behaves:

- which way it counts;
- whether it re-arms after terminal count;
- whether reloads alternate between two preset values A and B;
- how the output pin is formed;
- where the count enable, the gate and the hardware trigger come from.

Software drives the channel through six one-cycle command strobes. The outputs of the neighbouring channels (index n-1 and n+1) and the channel's own external input pin arrive as single-bit ports. Each of them can serve as a clock, a gate or a trigger source.

Alternating reloads are chosen by the toggle flip-flop. With the toggle output selected, the channel produces a PWM waveform: the high time is set by B and the low time by A, without software stepping in between periods.

Top module: `dual_reload_timer`

## Requirements
- R1: After synchronous reset the count is 0, the channel is stopped, the toggle is 0 and the output pin is 0.
- R2: Commands act one cycle after a strobe, and a cycle with every strobe at 0 changes nothing.
  - Start sets running and stop clears it; stop wins when both are given.
  - Load copies the reload value into the count: A, or B when mode bit 2 is 1 and the toggle is 1.
  - Clear zeroes the count, and it wins over load and trigger.
  - Toggle-set sets the toggle and toggle-clear clears it; set wins.
  - While the channel is stopped and no load, clear or trigger is given, the count holds.
- R3: With mode bit 0 = 0 (down), each enabled clock event while running decrements the count. An event at count 0 is a terminal count. With mode bit 1 = 1, a terminal count reloads the count and the channel keeps running.
- R4: With mode bit 0 = 1 (up), each enabled event increments the count, and the terminal count is at all ones. With mode bit 1 = 0, a terminal count clears running and the count holds the terminal value.
- R5: Every terminal count inverts the toggle. With mode bit 2 = 1, the reload at terminal count takes B when the inverted toggle is 1 and A when it is 0. With mode bit 2 = 0 it always takes A.
- R6: The pin is registered.
  - The raw output is the terminal-count pulse when mode bit 3 = 0, or the toggle when mode bit 3 = 1.
  - Mode bits 5:4 then give: 00 raw, 01 inverted, 10 forced 0, 11 forced 1.
- R7: The clock code is mode bits 17:14. Codes 0000, 0001, 0010 and 0011 count on every cycle, every 5th cycle, every 50th cycle and every 500th cycle (50, 10, 1 and 0.1 MHz). The prescalers run freely from reset.
- R8: Clock codes 01xx, 10xx and 11xx count on edges of the external input, the n-1 output or the n+1 output respectively. The low bits pick the edge: 01 rising, 10 falling, 11 either. Codes 0100, 1000 and 1100 never count.
- R9: Mode bits 12:11 pick the gate: 00 constant 1, 01 external input, 10 n-1 output, 11 n+1 output. Mode bit 13 is the gate level that blocks counting, and a blocked channel holds its count.
- R10: Mode bits 7:6 pick the trigger source (00 none, 01 external, 10 n-1, 11 n+1). Mode bits 9:8 pick the edge (00 none, 01 rising, 10 falling, 11 either). An accepted trigger loads the reload value and sets running. A trigger is accepted only while stopped, unless mode bit 10 is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (50 MHz nominal) |
| rst | input | 1 | Synchronous active-high reset |
| mode_i | input | 18 | Mode word; field layout as in the requirements |
| reload_a_i | input | WIDTH | Reload value A |
| reload_b_i | input | WIDTH | Reload value B |
| cmd_start_i | input | 1 | Start strobe |
| cmd_stop_i | input | 1 | Stop strobe |
| cmd_load_i | input | 1 | Load-from-reload strobe |
| cmd_clear_i | input | 1 | Count-clear strobe |
| cmd_tset_i | input | 1 | Toggle-set strobe |
| cmd_tclr_i | input | 1 | Toggle-clear strobe |
| ext_in_i | input | 1 | Channel external input pin (synchronous) |
| prev_out_i | input | 1 | Output of neighbour channel n-1 |
| next_out_i | input | 1 | Output of neighbour channel n+1 |
| count_o | output | WIDTH | Current count |
| running_o | output | 1 | Running status |
| toggle_o | output | 1 | Output toggle state |
| pin_o | output | 1 | Registered output pin level |

## Verification
Some properties are checked by assertions on every cycle:
- the count holds while the channel is stopped, gated off, or clocked by a reserved code;
- a down-count terminal event in repeat mode lands on A;
- a forced-low output stays low.

Other behaviour needs sequences of events and is shown only by the bench scenarios, where a behavioural model is compared cycle by cycle:
- the alternating A/B periods and the resulting PWM waveform;
- the prescaler rates;
- edge selection on each source;
- trigger acceptance with and without retrigger;
- strobe priorities.

// File: rtl/timer_pkg.sv
package timer_pkg;

  localparam int MODE_W = 18;

  typedef enum logic [1:0] {
    OUT_DIRECT = 2'b00,
    OUT_INVERT = 2'b01,
    OUT_LOW    = 2'b10,
    OUT_HIGH   = 2'b11
  } out_ctl_e;

  typedef struct packed {
    logic [3:0] clk_sel;
    logic       gate_pol;
    logic [1:0] gate_src;
    logic       retrig;
    logic [1:0] trig_edge;
    logic [1:0] trig_src;
    out_ctl_e   out_ctl;
    logic       out_tog;
    logic       alt_reload;
    logic       rep_en;
    logic       count_up;
  } tmr_mode_t;

  // edge code: 01 rising, 10 falling, 11 either, 00 none
  function automatic logic edge_pick(input logic [1:0] code, input logic rise,
                                     input logic fall);
    case (code)
      2'b01:   edge_pick = rise;
      2'b10:   edge_pick = fall;
      2'b11:   edge_pick = rise | fall;
      default: edge_pick = 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/tmr_divider.sv
module tmr_divider #(
  parameter int unsigned DIV = 5
) (
  input  logic clk,
  input  logic rst,
  output logic tick_o
);
  localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (cnt_q == LAST) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + CW'(1);
    end
  end

  assign tick_o = (cnt_q == LAST);
endmodule

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
  parameter int unsigned DIV_FAST = 5,
  parameter int unsigned DIV_MID  = 50,
  parameter int unsigned DIV_SLOW = 500
) (
  input  logic       clk,
  input  logic       rst,
  output logic [2:0] tick_o
);
  for (genvar i = 0; i < 3; i++) begin : g_div
    localparam int unsigned D = (i == 0) ? DIV_FAST : (i == 1) ? DIV_MID : DIV_SLOW;
    tmr_divider #(.DIV(D)) u_div (
      .clk   (clk),
      .rst   (rst),
      .tick_o(tick_o[i])
    );
  end
endmodule

// File: rtl/tmr_event_select.sv
module tmr_event_select
  import timer_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  tmr_mode_t mode_i,
  input  logic [2:0] tick_i,
  input  logic [2:0] src_i,      // [0] external, [1] n-1, [2] n+1
  output logic      cnt_tick_o,
  output logic      gate_open_o,
  output logic      trig_evt_o
);
  logic [2:0] last_q;
  logic [2:0] rise, fall;

  always_ff @(posedge clk) begin
    if (rst) last_q <= '0;
    else     last_q <= src_i;
  end

  for (genvar s = 0; s < 3; s++) begin : g_edge
    assign rise[s] = src_i[s] & ~last_q[s];
    assign fall[s] = ~src_i[s] & last_q[s];
  end

  logic [1:0] cgrp, tgrp;
  logic       gate_lvl;

  always_comb begin
    cgrp = mode_i.clk_sel[3:2];
    if (cgrp == 2'b00) begin
      case (mode_i.clk_sel[1:0])
        2'b00:   cnt_tick_o = 1'b1;
        2'b01:   cnt_tick_o = tick_i[0];
        2'b10:   cnt_tick_o = tick_i[1];
        default: cnt_tick_o = tick_i[2];
      endcase
    end else begin
      cnt_tick_o = edge_pick(mode_i.clk_sel[1:0], rise[cgrp-2'd1], fall[cgrp-2'd1]);
    end

    tgrp = mode_i.trig_src;
    if (tgrp == 2'b00) trig_evt_o = 1'b0;
    else trig_evt_o = edge_pick(mode_i.trig_edge, rise[tgrp-2'd1], fall[tgrp-2'd1]);

    if (mode_i.gate_src == 2'b00) gate_lvl = 1'b1;
    else gate_lvl = src_i[mode_i.gate_src-2'd1];
    gate_open_o = (gate_lvl != mode_i.gate_pol);
  end
endmodule

// File: rtl/tmr_count_core.sv
module tmr_count_core
  import timer_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  tmr_mode_t        mode_i,
  input  logic [WIDTH-1:0] reload_a_i,
  input  logic [WIDTH-1:0] reload_b_i,
  input  logic             cmd_start_i,
  input  logic             cmd_stop_i,
  input  logic             cmd_load_i,
  input  logic             cmd_clear_i,
  input  logic             cmd_tset_i,
  input  logic             cmd_tclr_i,
  input  logic             cnt_tick_i,
  input  logic             gate_open_i,
  input  logic             trig_evt_i,
  output logic [WIDTH-1:0] count_o,
  output logic             running_o,
  output logic             toggle_o,
  output logic             pin_o
);
  logic [WIDTH-1:0] cnt_q, cnt_d, term, cur_rl, tc_rl;
  logic run_q, run_d, tog_q, tog_d, pin_q, pin_d;
  logic trig_take, step_en, at_term, tc_evt, raw;

  always_comb begin
    term      = mode_i.count_up ? {WIDTH{1'b1}} : '0;
    trig_take = trig_evt_i && (!run_q || mode_i.retrig);
    step_en   = run_q && cnt_tick_i && gate_open_i;
    at_term   = (cnt_q == term);
    tc_evt    = step_en && at_term && !cmd_clear_i && !cmd_load_i && !trig_take;
    cur_rl    = (mode_i.alt_reload && tog_q) ? reload_b_i : reload_a_i;
    tc_rl     = (mode_i.alt_reload && !tog_q) ? reload_b_i : reload_a_i;

    cnt_d = cnt_q;
    if (cmd_clear_i) cnt_d = '0;
    else if (cmd_load_i || trig_take) cnt_d = cur_rl;
    else if (step_en) begin
      if (at_term) begin
        if (mode_i.rep_en) cnt_d = tc_rl;
      end else if (mode_i.count_up) cnt_d = cnt_q + WIDTH'(1);
      else cnt_d = cnt_q - WIDTH'(1);
    end

    run_d = run_q;
    if (cmd_stop_i) run_d = 1'b0;
    else if (cmd_start_i || trig_take) run_d = 1'b1;
    else if (tc_evt && !mode_i.rep_en) run_d = 1'b0;

    tog_d = tog_q;
    if (cmd_tset_i) tog_d = 1'b1;
    else if (cmd_tclr_i) tog_d = 1'b0;
    else if (tc_evt) tog_d = ~tog_q;

    raw = mode_i.out_tog ? tog_d : tc_evt;
    case (mode_i.out_ctl)
      OUT_DIRECT: pin_d = raw;
      OUT_INVERT: pin_d = ~raw;
      OUT_LOW:    pin_d = 1'b0;
      default:    pin_d = 1'b1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      run_q <= 1'b0;
      tog_q <= 1'b0;
      pin_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      run_q <= run_d;
      tog_q <= tog_d;
      pin_q <= pin_d;
    end
  end

  assign count_o   = cnt_q;
  assign running_o = run_q;
  assign toggle_o  = tog_q;
  assign pin_o     = pin_q;

  // R2: stopped channel holds its count absent load, clear and trigger
  assert_hold_stopped_R2: assert property (@(posedge clk) disable iff (rst)
    (!run_q && !cmd_clear_i && !cmd_load_i && !trig_evt_i) |=> $stable(cnt_q));

  // R3: down-count terminal event in repeat mode lands on A
  assert_reload_on_tc_R3: assert property (@(posedge clk) disable iff (rst)
    (run_q && cnt_tick_i && gate_open_i && cnt_q == '0 && !mode_i.count_up &&
     mode_i.rep_en && !mode_i.alt_reload && !cmd_clear_i && !cmd_load_i && !trig_evt_i)
    |=> (cnt_q == $past(reload_a_i)));

  // R6: forced-low output
  assert_force_low_R6: assert property (@(posedge clk) disable iff (rst)
    (mode_i.out_ctl == OUT_LOW) |=> !pin_q);

  // R8: reserved clock codes never count
  assert_reserved_clock_R8: assert property (@(posedge clk) disable iff (rst)
    (mode_i.clk_sel[1:0] == 2'b00 && mode_i.clk_sel[3:2] != 2'b00 &&
     !cmd_clear_i && !cmd_load_i && !trig_evt_i) |=> $stable(cnt_q));

  // R9: closed gate blocks counting
  assert_gate_blocks_R9: assert property (@(posedge clk) disable iff (rst)
    (!gate_open_i && !cmd_clear_i && !cmd_load_i && !trig_evt_i) |=> $stable(cnt_q));
endmodule

// File: rtl/dual_reload_timer.sv
module dual_reload_timer
  import timer_pkg::*;
#(
  parameter int          WIDTH    = 32,
  parameter int unsigned DIV_FAST = 5,
  parameter int unsigned DIV_MID  = 50,
  parameter int unsigned DIV_SLOW = 500
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [MODE_W-1:0] mode_i,
  input  logic [WIDTH-1:0]  reload_a_i,
  input  logic [WIDTH-1:0]  reload_b_i,
  input  logic              cmd_start_i,
  input  logic              cmd_stop_i,
  input  logic              cmd_load_i,
  input  logic              cmd_clear_i,
  input  logic              cmd_tset_i,
  input  logic              cmd_tclr_i,
  input  logic              ext_in_i,
  input  logic              prev_out_i,
  input  logic              next_out_i,
  output logic [WIDTH-1:0]  count_o,
  output logic              running_o,
  output logic              toggle_o,
  output logic              pin_o
);
  tmr_mode_t  mode;
  logic [2:0] ticks;
  logic       cnt_tick, gate_open, trig_evt;

  assign mode = tmr_mode_t'(mode_i);

  tmr_prescaler #(.DIV_FAST(DIV_FAST), .DIV_MID(DIV_MID), .DIV_SLOW(DIV_SLOW)) u_pre (
    .clk   (clk),
    .rst   (rst),
    .tick_o(ticks)
  );

  tmr_event_select u_sel (
    .clk        (clk),
    .rst        (rst),
    .mode_i     (mode),
    .tick_i     (ticks),
    .src_i      ({next_out_i, prev_out_i, ext_in_i}),
    .cnt_tick_o (cnt_tick),
    .gate_open_o(gate_open),
    .trig_evt_o (trig_evt)
  );

  tmr_count_core #(.WIDTH(WIDTH)) u_core (
    .clk        (clk),
    .rst        (rst),
    .mode_i     (mode),
    .reload_a_i (reload_a_i),
    .reload_b_i (reload_b_i),
    .cmd_start_i(cmd_start_i),
    .cmd_stop_i (cmd_stop_i),
    .cmd_load_i (cmd_load_i),
    .cmd_clear_i(cmd_clear_i),
    .cmd_tset_i (cmd_tset_i),
    .cmd_tclr_i (cmd_tclr_i),
    .cnt_tick_i (cnt_tick),
    .gate_open_i(gate_open),
    .trig_evt_i (trig_evt),
    .count_o    (count_o),
    .running_o  (running_o),
    .toggle_o   (toggle_o),
    .pin_o      (pin_o)
  );
endmodule

// File: tb/dual_reload_timer_bench.sv
module dual_reload_timer_bench;
  localparam int D1 = 5, D2 = 50, D3 = 500;

  logic clk = 0, rst = 1;
  logic [17:0] mode = '0;
  logic [31:0] ra = '0, rb = '0;
  logic [5:0]  cmd = '0;  // [0]start [1]stop [2]load [3]clear [4]tset [5]tclr
  logic ext = 0, prv = 0, nxt = 0;
  logic [31:0] count;
  logic running, toggle, pin;

  always #2 clk = ~clk;

  dual_reload_timer u_dual_reload_timer (
    .clk(clk), .rst(rst), .mode_i(mode), .reload_a_i(ra), .reload_b_i(rb),
    .cmd_start_i(cmd[0]), .cmd_stop_i(cmd[1]), .cmd_load_i(cmd[2]),
    .cmd_clear_i(cmd[3]), .cmd_tset_i(cmd[4]), .cmd_tclr_i(cmd[5]),
    .ext_in_i(ext), .prev_out_i(prv), .next_out_i(nxt),
    .count_o(count), .running_o(running), .toggle_o(toggle), .pin_o(pin));

  int checks = 0, fails = 0, cyc = 0;
  bit done = 0;
  string cur_req = "R1";

  task automatic check(input string req, input string what, input logic [31:0] got,
                       input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, got, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  logic [31:0] m_cnt;
  bit m_run, m_tog, m_pin;
  int ncyc;
  bit [2:0] l_src;

  function automatic bit edg(bit cur, bit last, int e);
    case (e)
      1: return cur && !last;
      2: return !cur && last;
      3: return cur != last;
      default: return 0;
    endcase
  endfunction

  always @(posedge clk) begin
    bit [2:0] s; bit tk, gopen, tev, take, tc, lvl, raw;
    int ck, g, e;
    logic [31:0] nxt_cnt;
    if (rst) begin
      m_cnt = 0; m_run = 0; m_tog = 0; m_pin = 0; ncyc = 0; l_src = 0;
    end else begin
      s = {nxt, prv, ext};
      ck = int'(mode[17:14]);
      g = ck / 4; e = ck % 4;
      if (g == 0) tk = (e == 0) ? 1 : (e == 1) ? (ncyc % D1 == D1-1)
                     : (e == 2) ? (ncyc % D2 == D2-1) : (ncyc % D3 == D3-1);
      else tk = edg(s[g-1], l_src[g-1], e);
      lvl = (mode[12:11] == 0) ? 1'b1 : s[int'(mode[12:11])-1];
      gopen = (lvl != mode[13]);
      tev = (mode[7:6] != 0) && edg(s[int'(mode[7:6])-1], l_src[int'(mode[7:6])-1], int'(mode[9:8]));
      take = tev && (!m_run || mode[10]);
      tc = 0;
      nxt_cnt = m_cnt;
      if (cmd[3]) nxt_cnt = 0;
      else if (cmd[2] || take) nxt_cnt = (mode[2] && m_tog) ? rb : ra;
      else if (m_run && tk && gopen) begin
        if (m_cnt == (mode[0] ? 32'hFFFF_FFFF : 32'h0)) begin
          tc = 1;
          if (mode[1]) nxt_cnt = (mode[2] && !m_tog) ? rb : ra;
        end else nxt_cnt = mode[0] ? m_cnt + 1 : m_cnt - 1;
      end
      if (cmd[1]) m_run = 0;
      else if (cmd[0] || take) m_run = 1;
      else if (tc && !mode[1]) m_run = 0;
      if (cmd[4]) m_tog = 1;
      else if (cmd[5]) m_tog = 0;
      else if (tc) m_tog = !m_tog;
      raw = mode[3] ? m_tog : tc;
      case (mode[5:4])
        2'b00: m_pin = raw;
        2'b01: m_pin = !raw;
        2'b10: m_pin = 0;
        default: m_pin = 1;
      endcase
      m_cnt = nxt_cnt;
      ncyc++;
      l_src = s;
    end
  end

  always @(negedge clk) begin
    cyc++;
    if (!rst && !done) begin
      check(cur_req, "count", count, m_cnt);
      check(cur_req, "running", 32'(running), 32'(m_run));
      check(cur_req, "toggle", 32'(toggle), 32'(m_tog));
      check(cur_req, "pin", 32'(pin), 32'(m_pin));
    end
    if (cyc > 100000 && !done) begin
      fails++; checks++;
      $display("FAIL watchdog %s actual=hung expected=finish", cur_req);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  // ---------------- stimulus ----------------
  function automatic logic [17:0] mk(input logic [3:0] ck, input logic gp, input logic [1:0] gs,
      input logic rt, input logic [1:0] te, input logic [1:0] ts, input logic [1:0] oc,
      input logic ot, input logic al, input logic rp, input logic up);
    return {ck, gp, gs, rt, te, ts, oc, ot, al, rp, up};
  endfunction

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic strobe(input logic [5:0] c);
    cmd = c; @(negedge clk); cmd = '0;
  endtask

  initial begin
    logic [31:0] held;
    step(3);
    rst = 0;
    step(1);
    check("R1", "reset count", count, 0);
    check("R1", "reset running", 32'(running), 0);
    check("R1", "reset toggle", 32'(toggle), 0);
    check("R1", "reset pin", 32'(pin), 0);

    // R2 commands
    cur_req = "R2";
    mode = mk(4'd0, 0, 2'd0, 0, 2'd0, 2'd0, 2'd0, 0, 0, 1, 0);
    ra = 32'd3;
    strobe(6'b000100);
    check("R2", "load A", count, 3);
    step(5);
    check("R2", "zero strobes keep count", count, 3);
    check("R2", "zero strobes keep stopped", 32'(running), 0);
    strobe(6'b001100);
    check("R2", "clear beats load", count, 0);
    strobe(6'b110000);
    check("R2", "tset beats tclr", 32'(toggle), 1);
    strobe(6'b100000);
    strobe(6'b000011);
    check("R2", "stop beats start", 32'(running), 0);

    // R3 down count with repeat
    cur_req = "R3";
    strobe(6'b000100);
    strobe(6'b000001);
    step(20);
    strobe(6'b000010);

    // R4 up count, no repeat
    cur_req = "R4";
    mode = mk(4'd0, 0, 2'd0, 0, 2'd0, 2'd0, 2'd0, 0, 0, 0, 1);
    ra = 32'hFFFF_FFFD;
    strobe(6'b000100);
    strobe(6'b000001);
    step(10);
    check("R4", "held at terminal", count, 32'hFFFF_FFFF);
    check("R4", "stopped after terminal", 32'(running), 0);

    // R5 alternating reload, toggle output (PWM)
    cur_req = "R5";
    mode = mk(4'd0, 0, 2'd0, 0, 2'd0, 2'd0, 2'd0, 1, 1, 1, 0);
    ra = 32'd2; rb = 32'd4;
    strobe(6'b100000);
    strobe(6'b000100);
    strobe(6'b000001);
    step(40);

    // R6 output control
    cur_req = "R6";
    mode[5:4] = 2'b01; step(10);
    mode[5:4] = 2'b10; step(10);
    mode[5:4] = 2'b11; step(2);
    check("R6", "forced high", 32'(pin), 1);
    step(8);
    mode[3] = 0; mode[5:4] = 2'b00; step(12);
    mode[5:4] = 2'b01; step(12);

    // R7 prescaled internal ticks
    cur_req = "R7";
    mode = mk(4'd1, 0, 2'd0, 0, 2'd0, 2'd0, 2'd0, 0, 0, 1, 0);
    ra = 32'd1000;
    strobe(6'b000100);
    strobe(6'b000001);
    step(30);
    mode[17:14] = 4'd2; step(120);
    mode[17:14] = 4'd3; step(1100);

    // R8 edge clocks and reserved codes
    cur_req = "R8";
    for (int code = 5; code < 16; code++) begin
      if (code % 4 == 0) continue;
      mode[17:14] = 4'(code);
      for (int k = 0; k < 8; k++) begin
        ext = ~ext; prv = ~prv; nxt = ~nxt;
        step(3);
      end
    end
    mode[17:14] = 4'd8;
    held = count;
    for (int k = 0; k < 6; k++) begin ext = ~ext; prv = ~prv; nxt = ~nxt; step(2); end
    check("R8", "reserved clock holds", count, held);
    ext = 0; prv = 0; nxt = 0; step(2);

    // R9 gate
    cur_req = "R9";
    mode = mk(4'd0, 0, 2'd1, 0, 2'd0, 2'd0, 2'd0, 0, 0, 1, 1);
    for (int k = 0; k < 6; k++) begin ext = ~ext; step(4); end
    mode[13] = 1;
    for (int k = 0; k < 6; k++) begin ext = ~ext; step(4); end
    mode[12:11] = 2'd3;
    for (int k = 0; k < 4; k++) begin nxt = ~nxt; step(3); end
    mode[12:11] = 2'd0;
    held = count; step(6);
    check("R9", "gate constant high blocks", count, held);
    ext = 0; nxt = 0; step(2);

    // R10 trigger and retrigger
    cur_req = "R10";
    strobe(6'b000010);
    mode = mk(4'd4, 0, 2'd0, 0, 2'd1, 2'd2, 2'd0, 0, 0, 1, 0);
    ra = 32'd77;
    step(2);
    prv = 1; step(1);
    check("R10", "trigger loads", count, 77);
    check("R10", "trigger starts", 32'(running), 1);
    prv = 0; ra = 32'd55; step(2);
    prv = 1; step(1);
    check("R10", "no retrigger while running", count, 77);
    prv = 0; step(2);
    mode[10] = 1; mode[7:6] = 2'd3; mode[9:8] = 2'd3; step(1);
    nxt = 1; step(1);
    check("R10", "retrigger accepted", count, 55);
    mode[17:14] = 4'd0; ra = 32'd6;
    nxt = 0; step(1);
    for (int k = 0; k < 5; k++) begin nxt = ~nxt; step(4); end
    step(5);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule